// File: doc/BRIEF.md
# I2C SCL Phase Timer

This block produces the serial clock of an I2C master and the bit-phase strobes that the master's bus engine uses to time its work on SDA. It runs from the peripheral clock. A 32-bit divider word sets the length of the low and high halves of SCL separately. Each half lasts eight peripheral clocks per unit of its count, so one SCL period is 8 × ((low + 1) + (high + 1)) peripheral clocks. The SCL rate is the peripheral clock rate divided by that period. With both counts at zero the period is 16 clocks.

The bus engine raises a run request while it needs SCL to toggle, and holds it for as long as the transfer lasts. Each period begins with the low half, followed by the high half. Four single-cycle strobes mark points in the period:
- the falling edge of SCL;
- the middle of the low half, where SDA may change;
- the rising edge of SCL;
- the middle of the high half, where SDA is sampled.

The engine uses the same strobes to place START and STOP conditions. The divider word is captured only when a low half begins. Writing the word while the block runs therefore never shortens the period in progress.

The block has no data stream. Every pin is a plain level or a single-cycle pulse, with no handshake and no back-pressure.

Top module: `scl_phase_timer`

## Requirements
- R1: The low-half count is taken from bits [15:0] of `div_cfg` and the high-half count from bits [31:16].
- R2: One clock after `en` and `run_req` are both seen high in the idle state, `scl_o` goes low. It stays low for exactly 8 × (low + 1) clocks, and every period starts with its low half.
- R3: The high half lasts exactly 8 × (high + 1) clocks, so one period is 8 × ((low + 1) + (high + 1)) clocks. With both counts zero the period is 16 clocks.
- R4: `stb_change` is high for one clock, 4 × (low + 1) clocks after the low half begins (cycle index 4 × (low + 1), counting the first low cycle as 0). It is low at all other times.
- R5: `stb_sample` is high for one clock at cycle index 4 × (high + 1) of the high half, and low at all other times.
- R6: `stb_fall` is high only in the first cycle of each low half, and `stb_rise` is high only in the first cycle of each high half.
- R7: `div_cfg` is sampled only at the clock edge that starts a low half. A change made at any other time takes effect at the next period.
- R8: One clock after `en` or `run_req` is seen low, `scl_o` is high and all strobes are low. A later request starts a fresh low half at cycle 0.
- R9: While `rst_n` is low, `scl_o` is high and all strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| run_req | input | 1 | Bus engine asks for SCL to toggle |
| div_cfg | input | 32 | Divider word: high count [31:16], low count [15:0] |
| scl_o | output | 1 | SCL drive level (0 = pull low, 1 = release) |
| stb_fall | output | 1 | First cycle of the low half |
| stb_change | output | 1 | Middle of the low half (SDA update point) |
| stb_rise | output | 1 | First cycle of the high half |
| stb_sample | output | 1 | Middle of the high half (SDA sample point) |

## Verification
The hardest case to reach from the ports is a divider write that lands inside a running period. The write must not disturb the period in progress, and the new value must take hold at exactly the next low-half start. The stimulus changes `div_cfg` at chosen cycles, once in the low half and once in the high half. The bench model switches to the new counts only for periods that begin after the change. A near-exhaustive sweep of small low and high counts covers the strobe positions, and a run with large counts confirms that the two fields sit in the right halves of the word.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } scl_phase_e;
endpackage

// File: rtl/scl_div_hold.sv
module scl_div_hold #(
  parameter int FIELD_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FIELD_W-1:0] cfg_lo,
  input  logic [FIELD_W-1:0] cfg_hi,
  output logic [FIELD_W-1:0] lo_q,
  output logic [FIELD_W-1:0] hi_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load) begin
      lo_q <= cfg_lo;
      hi_q <= cfg_hi;
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(lo_q) && $stable(hi_q)));
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_timing_pkg::*;
#(
  parameter int FIELD_W  = 16,
  parameter int SUB_LOG2 = 3,
  localparam int CW = FIELD_W + SUB_LOG2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               active,
  input  logic [FIELD_W-1:0] lo_q,
  input  logic [FIELD_W-1:0] hi_q,
  output scl_phase_e         phase_o,
  output logic [CW-1:0]      cnt_o,
  output logic               load_o
);
  scl_phase_e    phase_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lo_last, hi_last;
  logic          last;

  assign lo_last = {lo_q, {SUB_LOG2{1'b1}}};
  assign hi_last = {hi_q, {SUB_LOG2{1'b1}}};
  assign last    = (phase_q == PH_LOW)  ? (cnt_q == lo_last) :
                   (phase_q == PH_HIGH) ? (cnt_q == hi_last) : 1'b0;
  assign load_o  = active && ((phase_q == PH_IDLE) ||
                              ((phase_q == PH_HIGH) && last));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!active) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_q <= PH_LOW;
          cnt_q   <= '0;
        end
        PH_LOW: begin
          if (last) begin
            phase_q <= PH_HIGH;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        PH_HIGH: begin
          if (last) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign phase_o = phase_q;
  assign cnt_o   = cnt_q;

  // R2
  low_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase_q == PH_LOW && !last) |=>
      (phase_q == PH_LOW && cnt_q == $past(cnt_q) + CW'(1)));

  // R3
  high_to_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && phase_q == PH_HIGH && last) |=> (phase_q == PH_LOW && cnt_q == '0));
endmodule

// File: rtl/scl_strobe_dec.sv
module scl_strobe_dec
  import scl_timing_pkg::*;
#(
  parameter int FIELD_W  = 16,
  parameter int SUB_LOG2 = 3,
  localparam int CW = FIELD_W + SUB_LOG2
) (
  input  scl_phase_e         phase,
  input  logic [CW-1:0]      cnt,
  input  logic [FIELD_W-1:0] lo_q,
  input  logic [FIELD_W-1:0] hi_q,
  output logic               scl_o,
  output logic               stb_fall,
  output logic               stb_change,
  output logic               stb_rise,
  output logic               stb_sample
);
  logic [CW-1:0] lo_mid, hi_mid;

  assign lo_mid = CW'({1'b0, lo_q} + 1'b1) << (SUB_LOG2 - 1);
  assign hi_mid = CW'({1'b0, hi_q} + 1'b1) << (SUB_LOG2 - 1);

  always_comb begin
    scl_o      = (phase != PH_LOW);
    stb_fall   = (phase == PH_LOW)  && (cnt == '0);
    stb_change = (phase == PH_LOW)  && (cnt == lo_mid);
    stb_rise   = (phase == PH_HIGH) && (cnt == '0);
    stb_sample = (phase == PH_HIGH) && (cnt == hi_mid);
  end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
  parameter int FIELD_W  = 16,
  parameter int SUB_LOG2 = 3,
  localparam int DIV_W = 2 * FIELD_W,
  localparam int CW    = FIELD_W + SUB_LOG2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             run_req,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             scl_o,
  output logic             stb_fall,
  output logic             stb_change,
  output logic             stb_rise,
  output logic             stb_sample
);
  import scl_timing_pkg::*;

  logic               active, load;
  logic [FIELD_W-1:0] lo_q, hi_q;
  scl_phase_e         phase;
  logic [CW-1:0]      cnt;

  assign active = en && run_req;

  initial begin
    sub_log2_min_chk: assert (SUB_LOG2 >= 1);
  end

  scl_div_hold #(.FIELD_W(FIELD_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .cfg_lo (div_cfg[FIELD_W-1:0]),
    .cfg_hi (div_cfg[DIV_W-1:FIELD_W]),
    .lo_q   (lo_q),
    .hi_q   (hi_q)
  );

  scl_phase_seq #(.FIELD_W(FIELD_W), .SUB_LOG2(SUB_LOG2)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (active),
    .lo_q    (lo_q),
    .hi_q    (hi_q),
    .phase_o (phase),
    .cnt_o   (cnt),
    .load_o  (load)
  );

  scl_strobe_dec #(.FIELD_W(FIELD_W), .SUB_LOG2(SUB_LOG2)) u_dec (
    .phase      (phase),
    .cnt        (cnt),
    .lo_q       (lo_q),
    .hi_q       (hi_q),
    .scl_o      (scl_o),
    .stb_fall   (stb_fall),
    .stb_change (stb_change),
    .stb_rise   (stb_rise),
    .stb_sample (stb_sample)
  );

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (scl_o && !stb_fall && !stb_change && !stb_rise && !stb_sample));

  // R6
  fall_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> stb_fall);

  // R6
  rise_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_o) && $past(active) |-> stb_rise);

  // R2
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && scl_o && !stb_rise && !stb_sample && $past(!active)) |=> !scl_o);
endmodule

// File: tb/scl_phase_timer_test.sv
module scl_phase_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int NEVER = 1 << 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        run_req = 1'b0;
  logic [31:0] div_cfg = '0;
  logic        scl_o, stb_fall, stb_change, stb_rise, stb_sample;

  int n_cmp = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scl_phase_timer uut (
    .clk(clk), .rst_n(rst_n), .en(en), .run_req(run_req), .div_cfg(div_cfg),
    .scl_o(scl_o), .stb_fall(stb_fall), .stb_change(stb_change),
    .stb_rise(stb_rise), .stb_sample(stb_sample)
  );

  task automatic chk(input string req, input logic act, input logic exp, input int t);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s t=%0d act=%b exp=%b", req, t, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk({req, " scl"},    scl_o,      1'b1, -1);
    chk({req, " fall"},   stb_fall,   1'b0, -1);
    chk({req, " change"}, stb_change, 1'b0, -1);
    chk({req, " rise"},   stb_rise,   1'b0, -1);
    chk({req, " sample"}, stb_sample, 1'b0, -1);
  endtask

  // Called at a negedge. Starts a run and checks every cycle over nper periods.
  task automatic run_check(input int lo0, input int hi0, input int lo1, input int hi1,
                           input int change_t, input int nper, input string tag);
    int clo, chi, s, per, lo_len;
    clo = lo0; chi = hi0; s = 0;
    div_cfg = {16'(hi0), 16'(lo0)};
    run_req = 1'b1;
    for (int k = 0; k < nper; k++) begin
      if (k > 0 && change_t < s) begin clo = lo1; chi = hi1; end
      lo_len = 8 * (clo + 1);
      per = lo_len + 8 * (chi + 1);
      for (int pos = 0; pos < per; pos++) begin
        @(negedge clk);
        chk({"R2 R3 scl ", tag}, scl_o, logic'(pos >= lo_len), s + pos);
        chk({"R6 fall ", tag},   stb_fall, logic'(pos == 0), s + pos);
        chk({"R4 change ", tag}, stb_change, logic'(pos == 4 * (clo + 1)), s + pos);
        chk({"R6 rise ", tag},   stb_rise, logic'(pos == lo_len), s + pos);
        chk({"R5 sample ", tag}, stb_sample,
            logic'(pos == lo_len + 4 * (chi + 1)), s + pos);
        if (s + pos == change_t) div_cfg = {16'(hi1), 16'(lo1)};
      end
      s += per;
    end
    run_req = 1'b0;
    @(negedge clk);
    chk_idle({"R8 after ", tag});
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL R2 watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    en = 1'b1; run_req = 1'b1; div_cfg = 32'h0003_0002;
    repeat (3) @(negedge clk);
    chk_idle("R9 reset");
    run_req = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R9 post-reset idle");

    // Sweep small counts; L=H=0 gives the 16-clock period (R3).
    for (int l = 0; l < 4; l++)
      for (int h = 0; h < 4; h++)
        run_check(l, h, l, h, NEVER, 2, "sweep");

    // R1 field placement with asymmetric, wider counts
    run_check(37, 2, 37, 2, NEVER, 1, "R1 lo=37");
    run_check(1, 260, 1, 260, NEVER, 1, "R1 hi=260");

    // R7 change during low half, then during high half
    run_check(2, 1, 0, 3, 5, 3, "R7 mid-low");
    run_check(1, 2, 3, 0, 20, 3, "R7 mid-high");

    // R8 drop enable mid-run
    div_cfg = 32'h0001_0001;
    run_req = 1'b1;
    repeat (6) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk_idle("R8 en low");
    @(negedge clk);
    chk_idle("R8 en low hold");
    en = 1'b1;
    run_req = 1'b0;
    @(negedge clk);
    chk_idle("R8 no request");
    // R8 fresh restart from cycle 0
    run_check(1, 1, 1, 1, NEVER, 2, "R8 restart");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule